// File: doc/BRIEF.md
# Dual-Bank Transmit Buffer Controller

This block owns the transmit region of a shared byte-wide buffer memory. The region is either one bank or two equal banks used in ping-pong fashion. The host fills the current load bank one byte at a time. Each packet is stored as a two-byte length, low byte first, followed by its payload. The host commits each finished packet and then issues a start command for the bank.

A started bank is read by an internal engine. The engine walks the length prefixes and streams every committed packet of that bank back to back as a byte stream, marking the final byte of each packet. When the bank has been drained, the engine sets the bank's completion bit, clears the bank's write pointer and packet count, and raises an interrupt if the interrupt is enabled.

In two-bank modes, every accepted start hands loading over to the other bank. The host can therefore refill one bank while the other is on the wire. If that bank has also been started, transmission continues into it without a pause.

Top module: `tx_dual_bank_buf`

## Requirements
- R1: After reset, `load_bank` is 0, `bank_busy`, `done`, `start_err`, `irq`, `tx_valid` and `mem_we` are all 0, and `load_space` equals the size of one bank for the selected mode.
- R2: `cfg_size` selects the layout. Value 0 gives one bank of 2^BASE_AW bytes. Values 1, 2 and 3 give two banks of 2^BASE_AW, 2^(BASE_AW+1) and 2^(BASE_AW+2) bytes. `load_space` reports the bytes still free in the load bank, and 0 while that bank is busy. A byte written when no space is left is ignored (`mem_we` stays 0).
- R3: An accepted host byte is written with `mem_we`=1 to address base+offset. The base is 0 for bank 0 and one bank size for bank 1. The offset is the bank's write pointer, which then advances by one.
- R4: A started bank is sent in order. Each packet is read as a length (low byte, then high byte) followed by that many payload bytes. Every payload byte appears once on `tx_data` with `tx_valid`=1, and `tx_last`=1 marks the final byte of each packet. All committed packets of the bank are sent without further host action.
- R5: A start whose load bank holds zero committed packets is ignored and sets `start_err`.
- R6: A start on a load bank that is busy is ignored and sets `start_err`. Byte writes and commits to a busy bank are ignored.
- R7: In a two-bank mode, each accepted start toggles `load_bank`, so the host can fill the other bank while the started one transmits.
- R8: When a bank finishes and the other bank is already started, the other bank's first payload byte appears exactly 4 cycles after the finished bank's last byte.
- R9: In the cycle after a bank's last byte is output, that bank's `done` bit is 1, its `bank_busy` bit is 0, and its write pointer and packet count are back to zero.
- R10: Writing 1 to a bit of `host_done_clr` clears that `done` bit. `irq` is 1 exactly when `irq_en` is 1 and any `done` bit is 1.
- R11: With `cfg_size`=0, `load_bank` stays 0 after an accepted start, and bank 1 never becomes busy.
- R12: `host_err_clr` clears `start_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size | input | 2 | Bank layout select, changed only while both banks are idle |
| irq_en | input | 1 | Enables the interrupt output |
| host_wr | input | 1 | Write one byte into the load bank |
| host_wdata | input | 8 | Byte to write |
| host_commit | input | 1 | Count one more packet in the load bank |
| host_start | input | 1 | Start transmission of the load bank |
| host_done_clr | input | 2 | Write-one-to-clear for the per-bank done bits |
| host_err_clr | input | 1 | Clears the start error bit |
| load_bank | output | 1 | Bank currently being loaded by the host |
| load_space | output | BASE_AW+3 | Free bytes in the load bank |
| bank_busy | output | 2 | Per-bank started-and-not-finished flag |
| mem_we | output | 1 | Buffer RAM write enable |
| mem_waddr | output | BASE_AW+3 | Buffer RAM write address |
| mem_wdata | output | 8 | Buffer RAM write data |
| mem_re | output | 1 | Buffer RAM read enable |
| mem_raddr | output | BASE_AW+3 | Buffer RAM read address |
| mem_rdata | input | 8 | Buffer RAM read data, one cycle after `mem_re` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a packet |
| done | output | 2 | Per-bank completion bits |
| start_err | output | 1 | A start command was rejected |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on three properties of the inputs. `cfg_size` is held steady while any bank is busy. The RAM returns read data exactly one cycle after the address. The committed length prefixes fit inside the bank. The stimulus changes `cfg_size` only across a reset and uses a one-cycle registered RAM model. It builds every packet through a task that writes a correct length header before the payload, so the engine never reads past the data the host placed in a bank.

// File: rtl/txb_pkg.sv
// Package: shared constants and types for the dual-bank transmit buffer.
// Assumes exactly two banks; single-bank layouts simply leave bank 1 unused.
package txb_pkg;

    localparam int NUM_BANKS = 2;

    // Transmit engine states.
    typedef enum logic [2:0] {
        ENG_IDLE = 3'd0,
        ENG_LEN0 = 3'd1,
        ENG_LEN1 = 3'd2,
        ENG_LEN2 = 3'd3,
        ENG_DATA = 3'd4,
        ENG_DONE = 3'd5
    } eng_state_e;

    // Layout select codes.
    typedef enum logic [1:0] {
        LAYOUT_ONE    = 2'd0,
        LAYOUT_TWO_X1 = 2'd1,
        LAYOUT_TWO_X2 = 2'd2,
        LAYOUT_TWO_X4 = 2'd3
    } layout_e;

endpackage

// File: rtl/txb_bank_slot.sv
// Module: per-bank bookkeeping of write pointer, packet count and busy flag.
// Assumes arm and finish never target the same bank in one cycle; finish wins.
module txb_bank_slot #(
    parameter int PTR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] bank_size,
    input  logic             wr_req,
    input  logic             commit_req,
    input  logic             arm_req,
    input  logic             finish,
    output logic             wr_ok,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] pcount,
    output logic             armed
);

    // Accept a byte only while the bank is loading and not full.
    always_comb begin
        wr_ok = wr_req && !armed && (wptr < bank_size);
    end

    // Track fill level, committed packets and the started state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            pcount <= '0;
            armed  <= 1'b0;
        end else if (finish) begin
            wptr   <= '0;
            pcount <= '0;
            armed  <= 1'b0;
        end else begin
            if (wr_ok) begin
                wptr <= wptr + 1'b1;
            end
            if (commit_req && !armed) begin
                pcount <= pcount + 1'b1;
            end
            if (arm_req) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/txb_host_port.sv
// Module: host-side routing of writes, commits and starts to the load bank.
// Assumes the layout is steady while any bank is busy.
module txb_host_port #(
    parameter int PTR_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  two_bank,
    input  logic [PTR_W-1:0]      bank_size,
    input  logic                  host_wr,
    input  logic                  host_commit,
    input  logic                  host_start,
    input  logic [1:0]            armed,
    input  logic [1:0]            wr_ok,
    input  logic [1:0][PTR_W-1:0] wptr,
    input  logic [1:0][PTR_W-1:0] pcount,
    output logic                  load_bank,
    output logic [PTR_W-1:0]      load_space,
    output logic [1:0]            wr_req,
    output logic [1:0]            commit_req,
    output logic [1:0]            arm_req,
    output logic                  start_bad,
    output logic                  mem_we,
    output logic [PTR_W-1:0]      mem_waddr
);

    logic lb_q;
    logic start_ok;
    logic [PTR_W-1:0] base;

    // Effective load bank: always bank 0 in the single-bank layout.
    always_comb begin
        load_bank = two_bank ? lb_q : 1'b0;
    end

    // Decide whether a start is accepted and route the host strobes.
    always_comb begin
        start_ok   = host_start && !armed[load_bank] && (pcount[load_bank] != '0);
        start_bad  = host_start && !start_ok;
        wr_req     = '0;
        commit_req = '0;
        arm_req    = '0;
        wr_req[load_bank]     = host_wr;
        commit_req[load_bank] = host_commit;
        arm_req[load_bank]    = start_ok;
    end

    // Form the RAM write address and report free space.
    always_comb begin
        base       = load_bank ? bank_size : '0;
        mem_we     = |wr_ok;
        mem_waddr  = base + wptr[load_bank];
        load_space = armed[load_bank] ? '0 : (bank_size - wptr[load_bank]);
    end

    // Hand loading over to the other bank after each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_q <= 1'b0;
        end else if (start_ok && two_bank) begin
            lb_q <= ~lb_q;
        end
    end

endmodule

// File: rtl/txb_reader.sv
// Module: transmit engine that drains started banks packet by packet.
// Assumes a RAM with one cycle of read latency and correct length prefixes.
module txb_reader
    import txb_pkg::*;
#(
    parameter int PTR_W  = 14,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PTR_W-1:0]      bank_size,
    input  logic [1:0]            armed,
    input  logic [1:0][PTR_W-1:0] pcount,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  mem_re,
    output logic [PTR_W-1:0]      mem_raddr,
    output logic                  tx_valid,
    output logic                  tx_last,
    output logic [1:0]            finish
);

    localparam int LEN_W = 2 * DATA_W;

    eng_state_e        st, st_n;
    logic              cur, cur_n, last_b, last_b_n;
    logic [PTR_W-1:0]  ptr, ptr_n, pkts, pkts_n;
    logic [LEN_W-1:0]  rem, rem_n, len_w;
    logic [DATA_W-1:0] lo, lo_n;
    logic              data_rd, last_rd, end_pkt, launch, pick;
    logic              dv_q, dl_q;

    // Next-state logic: header reads, payload reads and bank hand-over.
    always_comb begin
        st_n     = st;
        cur_n    = cur;
        last_b_n = last_b;
        ptr_n    = ptr;
        pkts_n   = pkts;
        rem_n    = rem;
        lo_n     = lo;
        mem_re   = 1'b0;
        data_rd  = 1'b0;
        last_rd  = 1'b0;
        end_pkt  = 1'b0;
        launch   = 1'b0;
        pick     = 1'b0;
        finish   = '0;
        len_w    = {mem_rdata, lo};
        case (st)
            ENG_IDLE: begin
                if (armed[~last_b]) begin
                    launch = 1'b1;
                    pick   = ~last_b;
                end else if (armed[last_b]) begin
                    launch = 1'b1;
                    pick   = last_b;
                end
            end
            ENG_LEN0: begin
                mem_re = 1'b1;
                ptr_n  = ptr + 1'b1;
                st_n   = ENG_LEN1;
            end
            ENG_LEN1: begin
                mem_re = 1'b1;
                ptr_n  = ptr + 1'b1;
                lo_n   = mem_rdata;
                st_n   = ENG_LEN2;
            end
            ENG_LEN2: begin
                if (len_w == '0) begin
                    end_pkt = 1'b1;
                end else begin
                    mem_re  = 1'b1;
                    data_rd = 1'b1;
                    ptr_n   = ptr + 1'b1;
                    if (len_w == LEN_W'(1)) begin
                        last_rd = 1'b1;
                        end_pkt = 1'b1;
                    end else begin
                        rem_n = len_w - 1'b1;
                        st_n  = ENG_DATA;
                    end
                end
            end
            ENG_DATA: begin
                mem_re  = 1'b1;
                data_rd = 1'b1;
                ptr_n   = ptr + 1'b1;
                if (rem == LEN_W'(1)) begin
                    last_rd = 1'b1;
                    end_pkt = 1'b1;
                end else begin
                    rem_n = rem - 1'b1;
                end
            end
            ENG_DONE: begin
                finish[cur] = 1'b1;
                last_b_n    = cur;
                if (armed[~cur]) begin
                    launch = 1'b1;
                    pick   = ~cur;
                end else begin
                    st_n = ENG_IDLE;
                end
            end
            default: st_n = ENG_IDLE;
        endcase
        if (end_pkt) begin
            if (pkts == PTR_W'(1)) begin
                st_n = ENG_DONE;
            end else begin
                pkts_n = pkts - 1'b1;
                st_n   = ENG_LEN0;
            end
        end
        if (launch) begin
            cur_n  = pick;
            ptr_n  = '0;
            pkts_n = pcount[pick];
            st_n   = ENG_LEN0;
        end
    end

    // Bank-relative read pointer mapped onto the shared RAM.
    always_comb begin
        mem_raddr = (cur ? bank_size : '0) + ptr;
    end

    // Engine state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ENG_IDLE;
            cur    <= 1'b0;
            last_b <= 1'b1;
            ptr    <= '0;
            pkts   <= '0;
            rem    <= '0;
            lo     <= '0;
        end else begin
            st     <= st_n;
            cur    <= cur_n;
            last_b <= last_b_n;
            ptr    <= ptr_n;
            pkts   <= pkts_n;
            rem    <= rem_n;
            lo     <= lo_n;
        end
    end

    // Align the valid and last marks with the RAM read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q <= 1'b0;
            dl_q <= 1'b0;
        end else begin
            dv_q <= data_rd;
            dl_q <= last_rd;
        end
    end

    assign tx_valid = dv_q;
    assign tx_last  = dl_q;

endmodule

// File: rtl/txb_status.sv
// Module: per-bank completion bits, start error flag and interrupt.
// Assumes finish pulses last one cycle; a set wins over a clear.
module txb_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] finish,
    input  logic [1:0] done_clr,
    input  logic       start_bad,
    input  logic       err_clr,
    input  logic       irq_en,
    output logic [1:0] done,
    output logic       start_err,
    output logic       irq
);

    // Completion bits: set by the engine, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= '0;
        end else begin
            done <= (done & ~done_clr) | finish;
        end
    end

    // Sticky error for rejected start commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_err <= 1'b0;
        end else if (start_bad) begin
            start_err <= 1'b1;
        end else if (err_clr) begin
            start_err <= 1'b0;
        end
    end

    // Interrupt is the enabled OR of the completion bits.
    always_comb begin
        irq = irq_en && (done != 2'b00);
    end

endmodule

// File: rtl/tx_dual_bank_buf.sv
// Module: top of the dual-bank transmit buffer controller.
// Assumes an external dual-port byte RAM of 2^(BASE_AW+3) bytes with
// one-cycle read latency, and cfg_size changed only while both banks are idle.
module tx_dual_bank_buf
    import txb_pkg::*;
#(
    parameter int BASE_AW = 11,
    parameter int DATA_W  = 8,
    localparam int PTR_W  = BASE_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_size,
    input  logic              irq_en,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_commit,
    input  logic              host_start,
    input  logic [1:0]        host_done_clr,
    input  logic              host_err_clr,
    output logic              load_bank,
    output logic [PTR_W-1:0]  load_space,
    output logic [1:0]        bank_busy,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic [PTR_W-1:0]  mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    output logic [1:0]        done,
    output logic              start_err,
    output logic              irq
);

    localparam logic [PTR_W-1:0] SZ_BASE = PTR_W'(1) << BASE_AW;

    logic [PTR_W-1:0]               bank_size;
    logic                           two_bank;
    logic [NUM_BANKS-1:0]           wr_req, commit_req, arm_req, wr_ok, armed, finish;
    logic [NUM_BANKS-1:0][PTR_W-1:0] wptr, pcount;
    logic                           start_bad;

    // Decode the layout select into bank size and bank count.
    always_comb begin
        two_bank = (cfg_size != LAYOUT_ONE);
        case (layout_e'(cfg_size))
            LAYOUT_TWO_X2: bank_size = SZ_BASE << 1;
            LAYOUT_TWO_X4: bank_size = SZ_BASE << 2;
            default:       bank_size = SZ_BASE;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_slot
            txb_bank_slot #(.PTR_W(PTR_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .bank_size  (bank_size),
                .wr_req     (wr_req[g]),
                .commit_req (commit_req[g]),
                .arm_req    (arm_req[g]),
                .finish     (finish[g]),
                .wr_ok      (wr_ok[g]),
                .wptr       (wptr[g]),
                .pcount     (pcount[g]),
                .armed      (armed[g])
            );
        end
    endgenerate

    txb_host_port #(.PTR_W(PTR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .two_bank   (two_bank),
        .bank_size  (bank_size),
        .host_wr    (host_wr),
        .host_commit(host_commit),
        .host_start (host_start),
        .armed      (armed),
        .wr_ok      (wr_ok),
        .wptr       (wptr),
        .pcount     (pcount),
        .load_bank  (load_bank),
        .load_space (load_space),
        .wr_req     (wr_req),
        .commit_req (commit_req),
        .arm_req    (arm_req),
        .start_bad  (start_bad),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr)
    );

    txb_reader #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_size (bank_size),
        .armed     (armed),
        .pcount    (pcount),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .finish    (finish)
    );

    txb_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (finish),
        .done_clr  (host_done_clr),
        .start_bad (start_bad),
        .err_clr   (host_err_clr),
        .irq_en    (irq_en),
        .done      (done),
        .start_err (start_err),
        .irq       (irq)
    );

    assign mem_wdata = host_wdata;
    assign tx_data   = mem_rdata;
    assign bank_busy = armed;

endmodule

// File: rtl/txb_checker.sv
// Module: property checker bound to the transmit buffer top.
// Assumes cfg_size is steady while a bank is busy.
module txb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_size,
    input logic       irq_en,
    input logic       host_wr,
    input logic       host_start,
    input logic       load_bank,
    input logic [1:0] bank_busy,
    input logic       mem_we,
    input logic       tx_valid,
    input logic       tx_last,
    input logic [1:0] done,
    input logic       start_err,
    input logic       irq
);

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R4

    AST_TX_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (bank_busy != 2'b00)); // R4

    AST_BUSY_NEEDS_START0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_busy[0]) |-> $past(host_start)); // R7

    AST_BUSY_NEEDS_START1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_busy[1]) |-> $past(host_start)); // R7

    AST_BAD_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_start && bank_busy[load_bank]) |=> start_err); // R6

    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && bank_busy[load_bank]) |-> !mem_we); // R6

    AST_DONE0_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done[0]) |-> ($past(bank_busy[0]) && !bank_busy[0])); // R9

    AST_DONE1_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done[1]) |-> ($past(bank_busy[1]) && !bank_busy[1])); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R10

    AST_SINGLE_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size == 2'd0) |-> (!bank_busy[1] && !load_bank)); // R11

endmodule

bind tx_dual_bank_buf txb_checker u_txb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_size   (cfg_size),
    .irq_en     (irq_en),
    .host_wr    (host_wr),
    .host_start (host_start),
    .load_bank  (load_bank),
    .bank_busy  (bank_busy),
    .mem_we     (mem_we),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .done       (done),
    .start_err  (start_err),
    .irq        (irq)
);

// File: tb/test_tx_dual_bank_buf.sv
// Bench: scoreboard for the dual-bank transmit buffer with a RAM model.
module test_tx_dual_bank_buf;

    localparam int BASE_AW = 6;
    localparam int PTR_W   = BASE_AW + 3;
    localparam int RAM_N   = 1 << PTR_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_size = 2'd3;
    logic             irq_en = 1'b1;
    logic             host_wr = 1'b0;
    logic [7:0]       host_wdata = '0;
    logic             host_commit = 1'b0;
    logic             host_start = 1'b0;
    logic [1:0]       host_done_clr = '0;
    logic             host_err_clr = 1'b0;
    logic             load_bank;
    logic [PTR_W-1:0] load_space;
    logic [1:0]       bank_busy;
    logic             mem_we, mem_re;
    logic [PTR_W-1:0] mem_waddr, mem_raddr;
    logic [7:0]       mem_wdata, mem_rdata, tx_data;
    logic             tx_valid, tx_last, start_err, irq;
    logic [1:0]       done;

    int vecs = 0;
    int fails = 0;
    int cyc = 0;
    int prev_cyc = 0;
    int bwp [2];

    typedef struct {
        logic [7:0] d;
        logic       l;
        int         gap;
    } item_t;
    item_t exp_q[$];
    item_t mon_it;

    logic [7:0] ram [0:RAM_N-1];
    logic [7:0] rdata_q = '0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Byte RAM with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_we) ram[mem_waddr] <= mem_wdata;
        if (mem_re) rdata_q <= ram[mem_raddr];
    end
    assign mem_rdata = rdata_q;

    tx_dual_bank_buf #(.BASE_AW(BASE_AW)) i_tx_dual_bank_buf (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .irq_en(irq_en),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_commit(host_commit),
        .host_start(host_start), .host_done_clr(host_done_clr),
        .host_err_clr(host_err_clr), .load_bank(load_bank),
        .load_space(load_space), .bank_busy(bank_busy), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .done(done),
        .start_err(start_err), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int bsize();
        case (cfg_size)
            2'd2:    return 1 << (BASE_AW + 1);
            2'd3:    return 1 << (BASE_AW + 2);
            default: return 1 << BASE_AW;
        endcase
    endfunction

    // Monitor: pop expected bytes and compare as they leave the design.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                vecs++;
                fails++;
                $display("FAIL R4 unexpected byte actual %0d expected none", tx_data);
            end else begin
                mon_it = exp_q.pop_front();
                chk(tx_data == mon_it.d, "R4 data", tx_data, mon_it.d);
                chk(tx_last == mon_it.l, "R4 last", tx_last, mon_it.l);
                if (mon_it.gap >= 0)
                    chk((cyc - prev_cyc) == mon_it.gap, "R8 gap", cyc - prev_cyc, mon_it.gap);
            end
            prev_cyc = cyc;
        end
    end

    // All driver tasks start and end just after a rising edge.
    task automatic do_reset(input logic [1:0] sz);
        rst_n = 1'b0;
        cfg_size = sz;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        bwp[0] = 0;
        bwp[1] = 0;
        @(negedge clk);
        chk(load_bank == 1'b0 && bank_busy == 2'b00, "R1 bank", {load_bank, bank_busy}, 0);
        chk(done == 2'b00 && !start_err && !irq && !tx_valid && !mem_we, "R1 status",
            {done, start_err, irq, tx_valid, mem_we}, 0);
        chk(int'(load_space) == bsize(), "R1 space", load_space, bsize());
        @(posedge clk); #1;
    endtask

    task automatic wr_byte(input logic [7:0] d, input int bank, input bit acc, input string req);
        host_wr = 1'b1;
        host_wdata = d;
        @(negedge clk);
        chk(mem_we == acc, req, mem_we, acc);
        if (acc) begin
            chk(int'(mem_waddr) == bank * bsize() + bwp[bank], "R3 addr",
                mem_waddr, bank * bsize() + bwp[bank]);
            bwp[bank]++;
        end
        @(posedge clk); #1 host_wr = 1'b0;
    endtask

    task automatic commit();
        host_commit = 1'b1;
        @(posedge clk); #1 host_commit = 1'b0;
    endtask

    task automatic start();
        host_start = 1'b1;
        @(posedge clk); #1 host_start = 1'b0;
    endtask

    task automatic clr_done(input logic [1:0] m);
        host_done_clr = m;
        @(posedge clk); #1 host_done_clr = '0;
    endtask

    task automatic clr_err();
        host_err_clr = 1'b1;
        @(posedge clk); #1 host_err_clr = 1'b0;
    endtask

    // Driver: store one packet and push its bytes into the scoreboard.
    task automatic load_pkt(input int bank, input int len, input int seed, input int gap);
        item_t it;
        wr_byte(len[7:0], bank, 1'b1, "R3 hdr");
        wr_byte(len[15:8], bank, 1'b1, "R3 hdr");
        for (int i = 0; i < len; i++) begin
            wr_byte(8'((seed + i * 7) & 255), bank, 1'b1, "R3 data");
            it.d = 8'((seed + i * 7) & 255);
            it.l = (i == len - 1);
            it.gap = (i == 0) ? gap : -1;
            exp_q.push_back(it);
        end
        commit();
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (bank_busy != 2'b00 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(bank_busy == 2'b00, "R9 drain", bank_busy, 0);
        bwp[0] = 0;
        bwp[1] = 0;
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        // Two banks of 256 bytes.
        do_reset(2'd3);

        // R5: start with no committed packet is rejected.
        start();
        chk(start_err == 1'b1, "R5 err", start_err, 1);
        chk(bank_busy == 2'b00 && load_bank == 1'b0, "R5 ignored", {bank_busy, load_bank}, 0);
        clr_err();
        chk(start_err == 1'b0, "R12 clear", start_err, 0);

        // Bank 0: three chained packets.
        load_pkt(0, 1, 8'h11, -1);
        load_pkt(0, 40, 8'h20, -1);
        load_pkt(0, 50, 8'h90, -1);
        chk(int'(load_space) == 256 - 97, "R2 space", load_space, 256 - 97);
        start();
        chk(load_bank == 1'b1 && bank_busy == 2'b01, "R7 toggle", {load_bank, bank_busy}, 3'b101);

        // R7: fill bank 1 while bank 0 transmits, then queue it.
        load_pkt(1, 20, 8'h33, 4);
        load_pkt(1, 3, 8'h5a, -1);
        start();
        chk(load_bank == 1'b0 && bank_busy == 2'b11, "R7 both", {load_bank, bank_busy}, 3'b011);
        chk(load_space == '0, "R2 busy space", load_space, 0);

        // R6: writes, commits and starts on the busy bank do nothing.
        wr_byte(8'hee, 0, 1'b0, "R6 write");
        commit();
        start();
        chk(start_err == 1'b1, "R6 err", start_err, 1);
        chk(bank_busy[0] == 1'b1, "R6 still busy", bank_busy, 3);

        wait_idle();
        chk(done == 2'b11, "R9 done", done, 3);
        chk(int'(load_space) == 256, "R9 pointer reset", load_space, 256);
        chk(irq == 1'b1, "R10 irq on", irq, 1);
        clr_done(2'b01);
        chk(done == 2'b10 && irq, "R10 clr0", {done, irq}, 3'b101);
        clr_done(2'b10);
        chk(done == 2'b00 && !irq, "R10 clr1", {done, irq}, 0);
        clr_err();

        // R10: masked interrupt.
        irq_en = 1'b0;
        load_pkt(0, 4, 8'h70, -1);
        start();
        wait_idle();
        @(negedge clk);
        chk(done == 2'b01 && !irq, "R10 masked", {done, irq}, 3'b010);
        irq_en = 1'b1;
        #1 chk(irq == 1'b1, "R10 unmask", irq, 1);
        @(posedge clk); #1;
        clr_done(2'b11);

        // Single bank of 64 bytes.
        do_reset(2'd0);
        load_pkt(0, 10, 8'h41, -1);
        start();
        chk(load_bank == 1'b0 && bank_busy == 2'b01, "R11 no toggle", {load_bank, bank_busy}, 1);
        wait_idle();
        chk(done == 2'b01, "R11 done", done, 1);

        // R2: writes past the end of the bank are dropped.
        for (int i = 0; i < 64; i++) wr_byte(8'(i), 0, 1'b1, "R2 fill");
        @(negedge clk);
        chk(load_space == '0, "R2 full", load_space, 0);
        @(posedge clk); #1;
        for (int i = 0; i < 6; i++) wr_byte(8'hcc, 0, 1'b0, "R2 overflow");

        // Two banks of 64 bytes: bank 1 base is 64.
        do_reset(2'd1);
        load_pkt(0, 8, 8'h01, -1);
        start();
        load_pkt(1, 6, 8'hc0, -1);
        start();
        wait_idle();
        chk(done == 2'b11, "R9 both", done, 3);

        // Two banks of 128 bytes.
        do_reset(2'd2);
        load_pkt(0, 100, 8'h05, -1);
        chk(int'(load_space) == 128 - 102, "R2 x2 space", load_space, 128 - 102);
        start();
        load_pkt(1, 2, 8'h66, 4);
        start();
        wait_idle();

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R4 all sent", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule